// File: doc/BRIEF.md
# Bus Idle-Time and Completion Interrupt Controller

This block watches a single-wire consumer-electronics control bus and decides when a transfer is over. It marks the bus busy on the first falling edge of the line. It then measures how long the line has stayed high, in units of the nominal data-bit period, and declares the bus free once that idle time reaches a selectable threshold. It also produces the completion interrupt. Depending on a timing select, the interrupt fires when the acknowledge of the final byte is done, when the idle time expires, or at both points.

Around it, a bit decoder supplies a pulse when the last byte of a message has been acknowledged and a pulse when a transfer is aborted by an error. Software owns the idle-time setting. While a finished message is waiting for its idle time, that setting is locked so that the running measurement keeps its threshold. A source flag tells the interrupt handler whether the last interrupt came from idle detection or from frame completion or an error.

Top module: `sft_idle_ctrl`

## Requirements
- R1: After a synchronous reset, the busy flag, interrupt, source flag and lock flag read 0, and the idle-time setting reads 00.
- R2: A falling edge of the line, sampled at a clock edge, makes the busy flag read 1 after that edge, even if an error pulse arrives in the same cycle.
- R3: With the idle-time setting 00, 01 or 10, the bus becomes free once the line has been sampled high while busy on 3, 5 or 7 times the reference bit width consecutive clock edges. With a reference bit width of 4, 00 gives 12 edges and 01 gives 20 edges. A falling edge restarts the count.
- R4: Idle-time setting 11 disables idle detection, so the bus stays busy no matter how long the line is high.
- R5: An error pulse frees the bus after that edge, unless a falling edge occurs in the same cycle.
- R6: Interrupt timing select 00 gives one interrupt after the final-byte acknowledge pulse and another when the idle time expires.
- R7: Timing select 01 gives an interrupt for the final-byte acknowledge pulse only.
- R8: Timing select 10 gives an interrupt for idle-time expiry only, with the source flag 0. Timing select 11 gives neither.
- R9: An error pulse always gives an interrupt, with the source flag 1, whatever the timing select.
- R10: The source flag is updated only when an interrupt fires. It reads 1 for frame completion or error and 0 for idle expiry. When idle expiry coincides with frame completion or error, a single interrupt is given with the source flag 1.
- R11: A final-byte acknowledge pulse while the bus stays busy sets the lock flag, which clears when the bus becomes free. The lock flag is never 1 while the bus is free.
- R12: A write to the idle-time setting is ignored while the lock flag is 1. Otherwise the new value reads back after the write edge.
- R13: The interrupt is a one-cycle pulse that appears one clock after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of the bit-width count |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Bus line level, 1 = released (high) |
| bit_ticks_i | input | 8 | Nominal data-bit period in clock ticks |
| sft_wr_i | input | 1 | Write strobe for the idle-time setting |
| sft_wdata_i | input | 2 | New idle-time setting (00=3, 01=5, 10=7 bit periods, 11=off) |
| done_sel_i | input | 2 | Interrupt timing select (00 both, 01 frame, 10 idle, 11 none) |
| frame_end_i | input | 1 | Pulse: acknowledge of the final byte completed |
| error_i | input | 1 | Pulse: transfer aborted by an error |
| bus_busy_o | output | 1 | Bus busy flag |
| done_irq_o | output | 1 | Completion interrupt pulse |
| done_src_o | output | 1 | Source of last interrupt, 1 = frame/error, 0 = idle |
| sft_lock_o | output | 1 | Idle-time setting write lock |
| sft_sel_o | output | 2 | Current idle-time setting |

## Verification
Idle-time expiry and a final-byte acknowledge (or an error) can land in the same clock cycle. Both then want to raise the interrupt, and they disagree on the source flag. The bench provokes this from its own model: it holds the line high after a falling edge and pulses the acknowledge input exactly on the edge where the model predicts expiry. It then checks that one single-cycle pulse appears and that the source flag reads 1. The random phase also lets errors, writes and edges collide, and every cycle is compared with the reference model.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [1:0] {
    SFT_3   = 2'b00,
    SFT_5   = 2'b01,
    SFT_7   = 2'b10,
    SFT_OFF = 2'b11
  } sft_len_e;

  typedef enum logic [1:0] {
    DONE_BOTH  = 2'b00,
    DONE_FRAME = 2'b01,
    DONE_IDLE  = 2'b10,
    DONE_NONE  = 2'b11
  } done_mode_e;

  function automatic logic [2:0] sft_mult(input logic [1:0] sel);
    case (sel)
      SFT_3:   sft_mult = 3'd3;
      SFT_5:   sft_mult = 3'd5;
      SFT_7:   sft_mult = 3'd7;
      default: sft_mult = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/sft_line_mon.sv
module sft_line_mon (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic fall_o
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= line_i;
  end

  assign fall_o = line_q & ~line_i;
endmodule

// File: rtl/sft_idle_timer.sv
module sft_idle_timer
  import sft_pkg::*;
#(
  parameter int BIT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  input  logic             fall_i,
  input  logic             line_i,
  input  logic [1:0]       sel_i,
  input  logic [BIT_W-1:0] bit_ticks_i,
  output logic             hit_o
);
  localparam int CNT_W = BIT_W + 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr;
  logic             en;

  always_comb begin
    thr = CNT_W'(sft_mult(sel_i)) * CNT_W'(bit_ticks_i);
    en  = (sel_i != SFT_OFF) && (bit_ticks_i != '0);
  end

  // count high samples while busy; any falling edge or a free bus restarts
  always_ff @(posedge clk) begin
    if (rst || fall_i || !busy_i)        cnt_q <= '0;
    else if (line_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign hit_o = busy_i & ~fall_i & line_i & en & (cnt_q == thr - CNT_W'(1));

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0)); // R3
endmodule

// File: rtl/sft_irq_gen.sv
module sft_irq_gen
  import sft_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] done_sel_i,
  input  logic       frame_end_i,
  input  logic       hit_i,
  input  logic       error_i,
  output logic       irq_o,
  output logic       src_o
);
  logic fire_frame, fire_idle, fire_any, src_frame;

  always_comb begin
    fire_frame = frame_end_i & (done_sel_i == DONE_BOTH || done_sel_i == DONE_FRAME);
    fire_idle  = hit_i & (done_sel_i == DONE_BOTH || done_sel_i == DONE_IDLE);
    src_frame  = fire_frame | error_i;
    fire_any   = src_frame | fire_idle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      src_o <= 1'b0;
    end else begin
      irq_o <= fire_any;
      if (fire_any) src_o <= src_frame;
    end
  end

  AST_ERR_IRQ: assert property (@(posedge clk) disable iff (rst)
    error_i |=> (irq_o && src_o)); // R9
  AST_IDLE_SRC: assert property (@(posedge clk) disable iff (rst)
    (hit_i && !frame_end_i && !error_i && done_sel_i == DONE_IDLE) |=> (irq_o && !src_o)); // R8
endmodule

// File: rtl/sft_idle_ctrl.sv
module sft_idle_ctrl
  import sft_pkg::*;
#(
  parameter int BIT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_i,
  input  logic [BIT_W-1:0] bit_ticks_i,
  input  logic             sft_wr_i,
  input  logic [1:0]       sft_wdata_i,
  input  logic [1:0]       done_sel_i,
  input  logic             frame_end_i,
  input  logic             error_i,
  output logic             bus_busy_o,
  output logic             done_irq_o,
  output logic             done_src_o,
  output logic             sft_lock_o,
  output logic [1:0]       sft_sel_o
);
  logic fall, hit, busy_n;
  logic busy_q, lock_q;
  logic [1:0] sel_q;

  sft_line_mon u_line (
    .clk(clk), .rst(rst), .line_i(line_i), .fall_o(fall)
  );

  sft_idle_timer #(.BIT_W(BIT_W)) u_timer (
    .clk(clk), .rst(rst), .busy_i(busy_q), .fall_i(fall), .line_i(line_i),
    .sel_i(sel_q), .bit_ticks_i(bit_ticks_i), .hit_o(hit)
  );

  sft_irq_gen u_irq (
    .clk(clk), .rst(rst), .done_sel_i(done_sel_i), .frame_end_i(frame_end_i),
    .hit_i(hit), .error_i(error_i), .irq_o(done_irq_o), .src_o(done_src_o)
  );

  assign busy_n = fall | (busy_q & ~(hit | error_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      lock_q <= 1'b0;
      sel_q  <= SFT_3;
    end else begin
      busy_q <= busy_n;
      lock_q <= busy_n & (lock_q | frame_end_i);
      if (sft_wr_i && !lock_q) sel_q <= sft_wdata_i;
    end
  end

  assign bus_busy_o = busy_q;
  assign sft_lock_o = lock_q;
  assign sft_sel_o  = sel_q;

  AST_LOCK_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> busy_q); // R11
  AST_FALL_BUSY: assert property (@(posedge clk) disable iff (rst)
    fall |=> busy_q); // R2
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (lock_q && sft_wr_i) |=> $stable(sel_q)); // R12
endmodule

// File: tb/test_sft_idle_ctrl.sv
module test_sft_idle_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_d = 1'b1, line_d = 1'b1, fe_d = 1'b0, er_d = 1'b0, wr_d = 1'b0;
  logic [1:0] wd_d = 2'b00, ds_d = 2'b00;
  logic [7:0] bits_d = 8'd4;
  logic       busy, irq, src, lock;
  logic [1:0] sel;

  sft_idle_ctrl i_sft_idle_ctrl (
    .clk(clk), .rst(rst_d), .line_i(line_d), .bit_ticks_i(bits_d),
    .sft_wr_i(wr_d), .sft_wdata_i(wd_d), .done_sel_i(ds_d),
    .frame_end_i(fe_d), .error_i(er_d), .bus_busy_o(busy), .done_irq_o(irq),
    .done_src_o(src), .sft_lock_o(lock), .sft_sel_o(sel)
  );

  int n_chk = 0, n_bad = 0, irq_cnt = 0, irq_run = 0, irq_run_max = 0, cyc = 0;
  bit finished = 0;
  int m_prev, m_busy, m_cnt, m_lock, m_sel, m_irq, m_src;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int thr, n_busy, n_cnt;
    bit fall, hit, ff, fi;
    if (rst_d) begin
      m_prev = 1; m_busy = 0; m_cnt = 0; m_lock = 0; m_sel = 0; m_irq = 0; m_src = 0;
      return;
    end
    fall = (m_prev == 1) && !line_d;
    thr  = (m_sel == 3) ? 0 : (3 + 2 * m_sel) * int'(bits_d);
    hit  = m_busy != 0 && !fall && line_d && thr != 0 && (m_cnt + 1 == thr);
    ff   = fe_d && (ds_d == 0 || ds_d == 1);
    fi   = hit && (ds_d == 0 || ds_d == 2);
    n_busy = (fall || (m_busy != 0 && !(hit || er_d))) ? 1 : 0;
    if (fall || m_busy == 0) n_cnt = 0;
    else if (line_d && m_cnt != 2047) n_cnt = m_cnt + 1;
    else n_cnt = m_cnt;
    if (wr_d && m_lock == 0) m_sel = int'(wd_d);
    m_lock = (n_busy != 0 && (m_lock != 0 || fe_d)) ? 1 : 0;
    m_irq = (ff || fi || er_d) ? 1 : 0;
    if (m_irq != 0) m_src = (ff || er_d) ? 1 : 0;
    m_busy = n_busy; m_cnt = n_cnt; m_prev = line_d;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R2/R3/R5 busy", busy, m_busy);
    chk("R6/R13 irq", irq, m_irq);
    chk("R10 src", src, m_src);
    chk("R11 lock", lock, m_lock);
    chk("R12 sel", sel, m_sel);
    if (irq) begin irq_cnt++; irq_run++; if (irq_run > irq_run_max) irq_run_max = irq_run; end
    else irq_run = 0;
  endtask

  task automatic frame(int nbits);
    for (int b = 0; b < nbits; b++) begin
      line_d = 0; step(); step();
      line_d = 1; step(); step();
    end
  endtask

  task automatic last_ack();
    line_d = 0; fe_d = 1; step(); fe_d = 0; step();
  endtask

  task automatic idle_until_free(int max, output int n);
    line_d = 1; n = 0;
    do begin step(); n++; end while (busy && n < max);
  endtask

  task automatic write_sel(logic [1:0] v);
    wr_d = 1; wd_d = v; step(); wr_d = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  initial begin
    int n;
    logic [15:0] lf;
    @(negedge clk);
    step(); step();
    rst_d = 0;
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0); chk("R1 src", src, 0);
    chk("R1 lock", lock, 0); chk("R1 sel", sel, 0);

    // R3 / R6 / R11: setting 00, select both
    ds_d = 2'b00; irq_cnt = 0;
    frame(3); last_ack();
    chk("R11 lock after ack", lock, 1);
    idle_until_free(100, n);
    chk("R3 idle edges sel00", n, 12);
    chk("R6 two interrupts", irq_cnt, 2);
    chk("R11 lock cleared", lock, 0);
    chk("R13 pulse width", irq_run_max, 1);

    // R12: write blocked while locked, accepted afterwards
    frame(1); last_ack();
    write_sel(2'b10);
    chk("R12 blocked write", sel, 0);
    idle_until_free(100, n);
    chk("R12 threshold kept", n, 12);
    write_sel(2'b01);
    chk("R12 accepted write", sel, 1);

    // R7: frame-only timing, 5 bit periods
    ds_d = 2'b01; irq_cnt = 0;
    frame(2); last_ack();
    idle_until_free(100, n);
    chk("R3 idle edges sel01", n, 20);
    chk("R7 one interrupt", irq_cnt, 1);
    chk("R7 src frame", src, 1);

    // R8: idle-only, then none
    ds_d = 2'b10; irq_cnt = 0;
    frame(2); last_ack(); idle_until_free(100, n);
    chk("R8 idle-only count", irq_cnt, 1);
    chk("R8 idle src", src, 0);
    ds_d = 2'b11; irq_cnt = 0;
    frame(2); last_ack(); idle_until_free(100, n);
    chk("R8 none count", irq_cnt, 0);

    // R10: expiry and final ack in the same cycle
    write_sel(2'b00); ds_d = 2'b00;
    frame(1); line_d = 0; step(); step();
    line_d = 1;
    while (m_cnt + 1 != 12) step();
    fe_d = 1; step(); fe_d = 0;
    chk("R10 coincident irq", irq, 1);
    chk("R10 coincident src", src, 1);
    chk("R10 bus freed", busy, 0);
    step();
    chk("R10 single pulse", irq, 0);

    // R4 / R5 / R9: detection off, error frees bus
    write_sel(2'b11); ds_d = 2'b10;
    frame(1); line_d = 1;
    repeat (300) step();
    chk("R4 still busy", busy, 1);
    er_d = 1; step(); er_d = 0;
    chk("R5 error frees", busy, 0);
    chk("R9 error irq", irq, 1);
    chk("R9 error src", src, 1);

    // random phase, every cycle compared with the model
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'd0) line_d = ~line_d;
      fe_d = (lf[9:5] == 5'd3);
      er_d = (lf[15:10] == 6'd7);
      wr_d = (lf[7:4] == 4'd9);
      wd_d = lf[12:11];
      if (lf[8:1] == 8'd17) ds_d = lf[14:13];
      if (lf[11:2] == 10'd5) bits_d = {6'd0, lf[1:0]} + 8'd1;
      step();
    end
    fe_d = 0; er_d = 0; wr_d = 0;
    finish_run();
  end
endmodule